// File: doc/BRIEF.md
# Parallel Code Correlator Symbol Detector

This block turns a recovered chip stream back into symbols. A chip clock is assumed to be supplied already, for example by an external phase-locked loop, and one received chip arrives on every rising edge. The block keeps the sixteen most recent chips in a sliding window. Four correlators score that window in parallel against four fixed sixteen-chip code words. The four code words stand for a positive ADC sample, a negative ADC sample, a zero sample and a frame-start marker.

A symbol is reported when the best correlation reaches the threshold. The block then gives a one-cycle strobe, a two-bit symbol code and, for the frame-start word, a marker pulse. Positive and negative symbols also refresh a reconstructed one-bit ADC output. There is no separate framing logic: a correlation peak alone marks both where a symbol ends and which symbol it is. A short hold-off window after each report suppresses repeat reports of the same peak. A watchdog raises a loss-of-signal alarm when peaks stop arriving.

Top module: `chip_corr_detector`

## Requirements
- R1: While reset is held and right after it is released, sym_valid, frame_start, adc_bit and los_alarm are all 0.
- R2: chip_in = 1 counts as +1 and chip_in = 0 as -1. The window holds the last 16 chips, and the oldest chip lines up with bit 15 of each code word. Each score is agreements minus disagreements, from -16 to +16.
- R3: A detection happens when the highest score is at least 8 and no hold-off is running. sym_valid is then 1 for exactly one cycle, in the cycle after the clock edge that captured the chip completing the window.
- R4: sym_code gives the detected word as 0 = positive, 1 = negative, 2 = zero, 3 = frame-start. The code words are 16'h9AC5, 16'h9A3A, 16'h5F90 and 16'h3C5A, in that order.
- R5: When several scores reach the threshold on the same edge, the largest one wins. Equal scores resolve in the order positive, negative, zero, frame-start.
- R6: The 15 clock edges after a detection cannot detect again, even if a score crosses the threshold. The 16th edge can.
- R7: frame_start pulses together with sym_valid, and only when sym_code is 3.
- R8: adc_bit becomes 1 on a positive detection and 0 on a negative detection. It holds its value at every other edge.
- R9: los_alarm becomes 1 after 64 consecutive clock edges with no detection. It returns to 0 in the same cycle that sym_valid reports the next detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered chip clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_in | input | 1 | Received chip, 1 = +1, 0 = -1 |
| sym_valid | output | 1 | One-cycle detection strobe |
| sym_code | output | 2 | Detected symbol code |
| frame_start | output | 1 | Frame-start marker pulse |
| adc_bit | output | 1 | Reconstructed one-bit ADC sample |
| los_alarm | output | 1 | Loss-of-signal alarm |

## Verification
The hardest conditions to reach from the ports are a detection that the hold-off window suppresses, and a tie between two correlators. Neither happens in a clean stream of back-to-back symbols. The bench reaches the first by sending the positive word and then only the last twelve chips of the zero word: the zero word's top nibble equals the positive word's bottom nibble, so the window matches the zero word exactly twelve edges after the first report. It reaches the tie by sending, after a quiet stretch, a window that sits four chips away from both the positive and the negative word. Long runs of a constant chip push the watchdog past its limit.

// File: rtl/chip_corr_pkg.sv
package chip_corr_pkg;

  localparam int unsigned NUM_SYM = 4;

  typedef enum logic [1:0] {
    SYM_POS   = 2'd0,
    SYM_NEG   = 2'd1,
    SYM_ZERO  = 2'd2,
    SYM_FRAME = 2'd3
  } sym_e;

endpackage

// File: rtl/corr_unit.sv
module corr_unit #(
  parameter int unsigned LEN = 16,
  parameter int unsigned W   = 6,
  parameter logic [LEN-1:0] CODE = '0
) (
  input  logic [LEN-1:0]       win_i,
  output logic signed [W-1:0]  score_o
);

  // Bipolar correlation: +1 for each agreeing chip, -1 for each disagreeing one.
  function automatic logic signed [W-1:0] bipolar_score(input logic [LEN-1:0] w,
                                                        input logic [LEN-1:0] c);
    int agree;
    agree = 0;
    for (int i = 0; i < int'(LEN); i++) begin
      if (w[i] == c[i]) agree++;
    end
    return W'(2 * agree - int'(LEN));
  endfunction

  assign score_o = bipolar_score(win_i, CODE);

endmodule

// File: rtl/peak_select.sv
module peak_select #(
  parameter int unsigned NUM    = 4,
  parameter int unsigned W      = 6,
  parameter int          THRESH = 8,
  localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [W-1:0]      score_i [NUM],
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic signed [W-1:0]      best_o
);

  localparam logic signed [W-1:0] THR_S = W'(THRESH);

  // First index with a strictly larger score wins, so ties keep the lower index.
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    best_o = '0;
    for (int k = 0; k < int'(NUM); k++) begin
      if (score_i[k] >= THR_S && (!hit_o || score_i[k] > best_o)) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(k);
        best_o = score_i[k];
      end
    end
  end

  function automatic logic none_above(input logic signed [W-1:0] s [NUM],
                                      input logic signed [W-1:0] lim);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < int'(NUM); k++) if (s[k] > lim) ok = 1'b0;
    return ok;
  endfunction

  a_r3_threshold_met: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (best_o >= THR_S));

  a_r5_largest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> none_above(score_i, best_o));

  a_r5_winner_score: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (score_i[idx_o] == best_o));

endmodule

// File: rtl/detect_ctrl.sv
module detect_ctrl
  import chip_corr_pkg::*;
#(
  parameter int unsigned HOLDOFF   = 15,
  parameter int unsigned LOS_LIMIT = 64,
  localparam int unsigned HOLD_W = $clog2(HOLDOFF + 1),
  localparam int unsigned IDLE_W = $clog2(LOS_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic [1:0] idx_i,
  output logic       sym_valid_o,
  output logic [1:0] sym_code_o,
  output logic       frame_start_o,
  output logic       adc_bit_o,
  output logic       los_alarm_o
);

  logic [HOLD_W-1:0] hold_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              fire;
  logic              hold_busy;

  assign hold_busy = (hold_cnt != '0);
  assign fire      = hit_i && !hold_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (fire) begin
      hold_cnt <= HOLD_W'(HOLDOFF);
    end else if (hold_busy) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid_o   <= 1'b0;
      sym_code_o    <= '0;
      frame_start_o <= 1'b0;
      adc_bit_o     <= 1'b0;
    end else begin
      sym_valid_o   <= fire;
      frame_start_o <= fire && (idx_i == SYM_FRAME);
      if (fire) sym_code_o <= idx_i;
      if (fire && idx_i == SYM_POS) adc_bit_o <= 1'b1;
      else if (fire && idx_i == SYM_NEG) adc_bit_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt    <= '0;
      los_alarm_o <= 1'b0;
    end else if (fire) begin
      idle_cnt    <= '0;
      los_alarm_o <= 1'b0;
    end else if (idle_cnt != IDLE_W'(LOS_LIMIT)) begin
      idle_cnt    <= idle_cnt + 1'b1;
      los_alarm_o <= (idle_cnt >= IDLE_W'(LOS_LIMIT - 1));
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |=> !sym_valid_o);

  a_r6_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && hold_busy) |=> !sym_valid_o);

  a_r7_frame_marker: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (sym_valid_o && sym_code_o == SYM_FRAME));

  a_r8_adc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(adc_bit_o));

  a_r9_alarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> !los_alarm_o);

endmodule

// File: rtl/chip_corr_detector.sv
module chip_corr_detector
  import chip_corr_pkg::*;
#(
  parameter int unsigned CODE_LEN  = 16,
  parameter int          THRESH    = 8,
  parameter int unsigned HOLDOFF   = 15,
  parameter int unsigned LOS_LIMIT = 64,
  parameter logic [NUM_SYM-1:0][CODE_LEN-1:0] CODES =
    {16'h3C5A, 16'h5F90, 16'h9A3A, 16'h9AC5}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_in,
  output logic       sym_valid,
  output logic [1:0] sym_code,
  output logic       frame_start,
  output logic       adc_bit,
  output logic       los_alarm
);

  localparam int unsigned CORR_W = $clog2(CODE_LEN) + 2;

  logic [CODE_LEN-1:0]      win;
  logic signed [CORR_W-1:0] score [NUM_SYM];
  logic                     peak_hit;
  logic [1:0]               peak_idx;
  logic signed [CORR_W-1:0] peak_val;

  // Newest chip enters at bit 0; the oldest sits at bit CODE_LEN-1.
  always_ff @(posedge clk) begin
    if (!rst_n) win <= '0;
    else        win <= {win[CODE_LEN-2:0], chip_in};
  end

  for (genvar g = 0; g < int'(NUM_SYM); g++) begin : g_corr
    corr_unit #(
      .LEN  (CODE_LEN),
      .W    (CORR_W),
      .CODE (CODES[g])
    ) u_corr (
      .win_i   (win),
      .score_o (score[g])
    );
  end

  peak_select #(
    .NUM    (NUM_SYM),
    .W      (CORR_W),
    .THRESH (THRESH)
  ) u_peak (
    .clk     (clk),
    .rst_n   (rst_n),
    .score_i (score),
    .hit_o   (peak_hit),
    .idx_o   (peak_idx),
    .best_o  (peak_val)
  );

  detect_ctrl #(
    .HOLDOFF   (HOLDOFF),
    .LOS_LIMIT (LOS_LIMIT)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit_i         (peak_hit),
    .idx_i         (peak_idx),
    .sym_valid_o   (sym_valid),
    .sym_code_o    (sym_code),
    .frame_start_o (frame_start),
    .adc_bit_o     (adc_bit),
    .los_alarm_o   (los_alarm)
  );

  a_r2_score_range: assert property (@(posedge clk) disable iff (!rst_n)
    peak_hit |-> (peak_val <= CORR_W'(CODE_LEN)));

endmodule

// File: tb/chip_corr_detector_tb.sv
`timescale 1ns/1ps
module chip_corr_detector_tb;

  localparam logic [15:0] C_POS   = 16'h9AC5;
  localparam logic [15:0] C_NEG   = 16'h9A3A;
  localparam logic [15:0] C_ZERO  = 16'h5F90;
  localparam logic [15:0] C_FRAME = 16'h3C5A;

  typedef struct packed {
    logic       v;
    logic [1:0] code;
    logic       fs;
    logic       adc;
    logic       los;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_in = 1'b0;
  logic sym_valid, frame_start, adc_bit, los_alarm;
  logic [1:0] sym_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t exp_q[$];

  logic [15:0] m_win = '0;
  int m_hold = 0;
  int m_idle = 0;
  logic m_adc = 1'b0;
  logic m_los = 1'b0;
  logic [1:0] m_code = '0;

  always #2.5 clk = ~clk;

  chip_corr_detector u_dut (
    .clk(clk), .rst_n(rst_n), .chip_in(chip_in),
    .sym_valid(sym_valid), .sym_code(sym_code), .frame_start(frame_start),
    .adc_bit(adc_bit), .los_alarm(los_alarm)
  );

  function automatic int score_of(input logic [15:0] w, input logic [15:0] c);
    return 16 - 2 * $countones(w ^ c);
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Driver: drives one chip and pushes what the outputs must show after the next edge.
  task automatic send_chip(input logic b);
    int sc [4];
    int best;
    int pick;
    logic fire;
    exp_t e;
    @(negedge clk);
    chip_in = b;
    sc[0] = score_of(m_win, C_POS);
    sc[1] = score_of(m_win, C_NEG);
    sc[2] = score_of(m_win, C_ZERO);
    sc[3] = score_of(m_win, C_FRAME);
    best = sc[0];
    for (int k = 1; k < 4; k++) if (sc[k] > best) best = sc[k];
    pick = 3;
    for (int k = 3; k >= 0; k--) if (sc[k] == best) pick = k;
    fire = (best >= 8) && (m_hold == 0);
    if (fire) begin
      m_hold = 15;
      m_idle = 0;
      m_los = 1'b0;
      m_code = 2'(pick);
      if (pick == 0) m_adc = 1'b1;
      if (pick == 1) m_adc = 1'b0;
    end else begin
      if (m_hold > 0) m_hold--;
      if (m_idle < 64) m_idle++;
      m_los = (m_idle >= 64);
    end
    e.v = fire;
    e.code = m_code;
    e.fs = fire && (pick == 3);
    e.adc = m_adc;
    e.los = m_los;
    exp_q.push_back(e);
    m_win = {m_win[14:0], b};
  endtask

  task automatic send_word(input logic [15:0] w, input int nchips);
    for (int i = nchips - 1; i >= 0; i--) send_chip(w[i]);
  endtask

  task automatic send_const(input logic b, input int n);
    for (int i = 0; i < n; i++) send_chip(b);
  endtask

  // Monitor: pops one expectation per edge once the driver has queued it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R3 R6 sym_valid", {1'b0, sym_valid}, {1'b0, e.v});
      if (e.v) check("R2 R4 R5 sym_code", sym_code, e.code);
      check("R7 frame_start", {1'b0, frame_start}, {1'b0, e.fs});
      check("R8 adc_bit", {1'b0, adc_bit}, {1'b0, e.adc});
      check("R9 los_alarm", {1'b0, los_alarm}, {1'b0, e.los});
    end
  end

  initial begin
    logic [15:0] tie_w;
    logic [15:0] diff;
    int flips;
    repeat (4) @(negedge clk);
    check("R1 valid in reset", {1'b0, sym_valid}, 2'd0);
    check("R1 alarm in reset", {1'b0, los_alarm}, 2'd0);
    rst_n = 1'b1;
    check("R1 adc after reset", {1'b0, adc_bit}, 2'd0);
    check("R1 frame after reset", {1'b0, frame_start}, 2'd0);

    // Clean symbol stream in every order
    send_word(C_POS, 16);
    send_word(C_NEG, 16);
    send_word(C_ZERO, 16);
    send_word(C_FRAME, 16);
    send_word(C_POS, 16);
    send_word(C_FRAME, 16);
    send_word(C_NEG, 16);

    // Hold-off: zero word completes 12 edges after the positive report
    send_const(1'b0, 20);
    send_word(C_POS, 16);
    send_word(C_ZERO, 12);
    send_const(1'b0, 20);

    // Long quiet stretch drives the alarm, then a symbol clears it
    send_const(1'b0, 100);
    check("R9 alarm raised after quiet", {1'b0, los_alarm}, 2'd1);
    send_word(C_NEG, 16);
    send_const(1'b1, 2);
    check("R9 alarm cleared by detection", {1'b0, los_alarm}, 2'd0);

    // Tie between positive and negative words: four of their differing chips flipped
    diff = C_POS ^ C_NEG;
    tie_w = C_POS;
    flips = 0;
    for (int i = 0; i < 16; i++) begin
      if (diff[i] && flips < 4) begin
        tie_w[i] = ~tie_w[i];
        flips++;
      end
    end
    send_const(1'b0, 40);
    send_word(tie_w, 16);
    send_const(1'b0, 30);

    // Random chips and random symbol sequences
    for (int r = 0; r < 300; r++) send_chip(1'($urandom_range(0, 1)));
    for (int s = 0; s < 60; s++) begin
      case ($urandom_range(0, 3))
        0: send_word(C_POS, 16);
        1: send_word(C_NEG, 16);
        2: send_word(C_ZERO, 16);
        default: send_word(C_FRAME, 16);
      endcase
    end

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule